// File: doc/BRIEF.md
# Byte-Wide Clock Register Front End With Shadow Copy

This block sits between a byte-wide memory bus and a running time-of-day counter chain. It decodes a 15-bit byte address space: the eight highest addresses hold a control byte and seven time bytes (seconds, minutes, hours, day of week, date, month, year, all BCD with hours in 24-hour form). Every lower address is ordinary storage held in a synchronous RAM array. The counter chain itself lives outside the block. It presents its current count on `live_time` and pulses `cnt_tick` each time it advances. The block hands staged values back to it through `cnt_load` / `cnt_load_val`.

Software never reads the counters directly. It sees a shadow copy that follows the counters on each tick while tracking, and it controls that copy through two bits of the control byte. The hold-read bit (bit 6) freezes the copy so that a multi-byte read is coherent. The set-time bit (bit 7) freezes the copy so that software can stage a new time, and clearing it commits the staged bytes into the counters. The counters never stop, so no time is lost. A power-fail input forces chip enable inactive.

A four-state controller governs the shadow copy. Its states are TRACK (copy reloads on every tick), FROZEN (hold-read set, set-time clear), STAGE (set-time set) and COMMIT (a single cycle that pulses the counter load). The transitions are: TRACK to STAGE when set-time is written 1, and TRACK to FROZEN when only hold-read is written 1. FROZEN goes to STAGE when set-time is written 1 and returns to TRACK when hold-read is written 0. STAGE goes to COMMIT when set-time is written 0. COMMIT always leaves after one cycle, to STAGE, FROZEN or TRACK according to the control bits then in force.

Top module: `rtc_bytewide_front`

## Requirements
- R1: Addresses 0x7FF8 to 0x7FFF are the register slots, in the order control, seconds, minutes, hours, day, date, month, year. Every lower address reaches the RAM array, which keeps only the low RAM_AW (default 10) address bits, so addresses equal modulo 1024 share a byte. Read data appears on `rdata` with `rdata_vld` high in the cycle after the read cycle. `rdata` is 0 whenever `rdata_vld` is low.
- R2: A read cycle is `chip_en`=1, `out_en`=1, `wr_en`=0. A write cycle is `chip_en`=1, `wr_en`=1, regardless of `out_en`, and a write produces no read. With `chip_en`=0, neither reads nor writes take place.
- R3: When the control byte has bit 6 and bit 7 clear and no commit is in progress, a `cnt_tick` cycle reloads all seven shadow bytes from `live_time`. Seconds are bits 7:0, and minutes, hours, day, date, month and year follow in ascending byte lanes up to bits 55:48.
- R4: While control bit 6 (hold-read) is 1, the shadow bytes ignore ticks and keep the values they held when the bit was set.
- R5: After bit 6 is written 0 (with bit 7 clear), the next tick refreshes all seven shadow bytes together.
- R6: While control bit 7 (set-time) is 1, ticks do not reload the shadow bytes. Writes to the time slots store into them, and reads return the staged values. Control bit 7 reads back as 1.
- R7: Writing control bit 7 from 1 to 0 raises `cnt_load` for exactly one cycle, the cycle after the write, with `cnt_load_val` carrying the seven staged bytes in the R3 lane layout. The next state follows bit 6: tracking resumes if it is 0, and the copy stays frozen if it is 1.
- R8: While `pwr_fail` is 1, no write changes RAM, shadow bytes or control bits, and no read returns data.
- R9: Control bits 5:0 are plain read/write storage. After reset the control byte, the shadow bytes, `rdata`, `rdata_vld` and `cnt_load` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_fail | input | 1 | Supply out of tolerance; blocks all accesses |
| chip_en | input | 1 | Chip enable, active high, sampled on the clock |
| wr_en | input | 1 | Write enable, active high |
| out_en | input | 1 | Output enable, active high |
| addr | input | 15 | Byte address |
| wdata | input | 8 | Write data |
| cnt_tick | input | 1 | One-cycle pulse when the counter chain advances |
| live_time | input | 56 | Current count from the counter chain, seven BCD bytes |
| rdata | output | 8 | Read data, registered |
| rdata_vld | output | 1 | High the cycle after an accepted read |
| cnt_load | output | 1 | One-cycle request to load the counter chain |
| cnt_load_val | output | 56 | Staged time bytes to load |

## Verification
On every cycle, the assertions check that the controller state agrees with the two hold bits, that a commit lasts one cycle and follows only a set-time clear, and that a held shadow copy stays stable without a bus write. They also check that a tracking tick copies the live count, and that power fail or a write suppresses read data. Only the bench's scenarios can show the end-to-end effects. These are address aliasing in the RAM, a frozen copy returning the same bytes while the live counters run on, and the refresh one tick after hold-read is released. They also include staged bytes arriving in the counter chain and showing up again after the following tick, and blocked writes leaving no trace once power returns.

// File: rtl/rtc_fe_pkg.sv
package rtc_fe_pkg;

    localparam int TIME_BYTES = 7;
    localparam int SLOT_COUNT = TIME_BYTES + 1;
    localparam int SLOT_W     = $clog2(SLOT_COUNT);
    localparam int SETT_BIT   = 7;
    localparam int HOLD_BIT   = 6;
    localparam int SPARE_W    = 6;

    typedef enum logic [1:0] {
        MODE_TRACK  = 2'd0,
        MODE_FROZEN = 2'd1,
        MODE_STAGE  = 2'd2,
        MODE_COMMIT = 2'd3
    } mode_e;

endpackage

// File: rtl/rtc_ram_store.sv
module rtc_ram_store #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        if (re) begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/rtc_hold_fsm.sv
module rtc_hold_fsm
    import rtc_fe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wdata,
    output logic [7:0] ctrl_rdata,
    output logic       track_ok,
    output logic       load_pulse
);

    mode_e              state_q;
    mode_e              state_d;
    logic               sett_q;
    logic               hold_q;
    logic [SPARE_W-1:0] spare_q;
    logic               sett_d;
    logic               hold_d;

    // Control bits as they stand after this cycle's bus write
    always_comb begin
        sett_d = sett_q;
        hold_d = hold_q;
        if (ctrl_we) begin
            sett_d = ctrl_wdata[SETT_BIT];
            hold_d = ctrl_wdata[HOLD_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sett_q  <= 1'b0;
            hold_q  <= 1'b0;
            spare_q <= '0;
        end else begin
            sett_q <= sett_d;
            hold_q <= hold_d;
            if (ctrl_we) begin
                spare_q <= ctrl_wdata[SPARE_W-1:0];
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_TRACK: begin
                if (sett_d)      state_d = MODE_STAGE;
                else if (hold_d) state_d = MODE_FROZEN;
            end
            MODE_FROZEN: begin
                if (sett_d)       state_d = MODE_STAGE;
                else if (!hold_d) state_d = MODE_TRACK;
            end
            MODE_STAGE: begin
                if (!sett_d)     state_d = MODE_COMMIT;
            end
            MODE_COMMIT: begin
                if (sett_d)      state_d = MODE_STAGE;
                else if (hold_d) state_d = MODE_FROZEN;
                else             state_d = MODE_TRACK;
            end
            default:             state_d = MODE_TRACK;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_TRACK;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        track_ok   = 1'b0;
        load_pulse = 1'b0;
        unique case (state_q)
            MODE_TRACK:  track_ok   = 1'b1;
            MODE_FROZEN: track_ok   = 1'b0;
            MODE_STAGE:  track_ok   = 1'b0;
            MODE_COMMIT: load_pulse = 1'b1;
            default:     track_ok   = 1'b0;
        endcase
        ctrl_rdata = {sett_q, hold_q, spare_q};
    end

    AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_COMMIT) |=> (state_q != MODE_COMMIT)); // R7
    AST_COMMIT_AFTER_SETT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |-> (!sett_q && $past(sett_q))); // R7
    AST_SETT_MEANS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        sett_q |-> (state_q == MODE_STAGE)); // R6
    AST_HOLD_MEANS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !sett_q && state_q != MODE_COMMIT) |-> (state_q == MODE_FROZEN)); // R4

endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
    import rtc_fe_pkg::*;
#(
    parameter int NBYTES = TIME_BYTES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                track_ok,
    input  logic                tick,
    input  logic [NBYTES*8-1:0] live_time,
    input  logic                wr_en,
    input  logic [SLOT_W-1:0]   wr_idx,
    input  logic [7:0]          wr_data,
    output logic [NBYTES*8-1:0] vis_bus
);

    logic reload;
    assign reload = track_ok & tick;

    for (genvar gi = 0; gi < NBYTES; gi++) begin : g_byte
        logic [7:0] byte_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (wr_en && wr_idx == SLOT_W'(gi)) begin
                byte_q <= wr_data;
            end else if (reload) begin
                byte_q <= live_time[gi*8 +: 8];
            end
        end
        assign vis_bus[gi*8 +: 8] = byte_q;
    end

    AST_HELD_COPY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!track_ok && !wr_en) |=> $stable(vis_bus)); // R4
    AST_TRACK_FOLLOWS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (track_ok && tick && !wr_en) |=> (vis_bus == $past(live_time))); // R3

endmodule

// File: rtl/rtc_bytewide_front.sv
module rtc_bytewide_front
    import rtc_fe_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int RAM_AW = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pwr_fail,
    input  logic                    chip_en,
    input  logic                    wr_en,
    input  logic                    out_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [7:0]              wdata,
    input  logic                    cnt_tick,
    input  logic [TIME_BYTES*8-1:0] live_time,
    output logic [7:0]              rdata,
    output logic                    rdata_vld,
    output logic                    cnt_load,
    output logic [TIME_BYTES*8-1:0] cnt_load_val
);

    localparam logic [ADDR_W-1:0] REG_BASE = ADDR_W'((1 << ADDR_W) - SLOT_COUNT);

    logic                    ce_ok;
    logic                    acc_wr;
    logic                    acc_rd;
    logic                    in_regs;
    logic [SLOT_W-1:0]       slot;
    logic                    ctrl_we;
    logic                    time_we;
    logic [SLOT_W-1:0]       time_idx;
    logic                    ram_we;
    logic                    ram_re;
    logic [7:0]              ram_q;
    logic [7:0]              ctrl_rdata;
    logic                    track_ok;
    logic                    load_pulse;
    logic [TIME_BYTES*8-1:0] vis_bus;
    logic [7:0]              reg_byte;
    logic [7:0]              reg_q;
    logic                    rd_q;
    logic                    regsel_q;

    // Access decode: power fail masks chip enable, write wins over read
    assign ce_ok    = chip_en & ~pwr_fail;
    assign acc_wr   = ce_ok & wr_en;
    assign acc_rd   = ce_ok & out_en & ~wr_en;
    assign in_regs  = (addr >= REG_BASE);
    assign slot     = addr[SLOT_W-1:0];
    assign ctrl_we  = acc_wr & in_regs & (slot == '0);
    assign time_we  = acc_wr & in_regs & (slot != '0);
    assign time_idx = slot - SLOT_W'(1);
    assign ram_we   = acc_wr & ~in_regs;
    assign ram_re   = acc_rd & ~in_regs;

    rtc_ram_store #(
        .AW (RAM_AW),
        .DW (8)
    ) i_ram (
        .clk   (clk),
        .we    (ram_we),
        .re    (ram_re),
        .addr  (addr[RAM_AW-1:0]),
        .wdata (wdata),
        .rdata (ram_q)
    );

    rtc_hold_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (wdata),
        .ctrl_rdata (ctrl_rdata),
        .track_ok   (track_ok),
        .load_pulse (load_pulse)
    );

    rtc_shadow_regs #(
        .NBYTES (TIME_BYTES)
    ) i_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .track_ok  (track_ok),
        .tick      (cnt_tick),
        .live_time (live_time),
        .wr_en     (time_we),
        .wr_idx    (time_idx),
        .wr_data   (wdata),
        .vis_bus   (vis_bus)
    );

    // Register-slot read mux
    always_comb begin
        if (slot == '0) begin
            reg_byte = ctrl_rdata;
        end else begin
            reg_byte = vis_bus[time_idx*8 +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q     <= 1'b0;
            regsel_q <= 1'b0;
            reg_q    <= '0;
        end else begin
            rd_q     <= acc_rd;
            regsel_q <= acc_rd & in_regs;
            if (acc_rd && in_regs) begin
                reg_q <= reg_byte;
            end
        end
    end

    assign rdata        = !rd_q ? 8'h00 : (regsel_q ? reg_q : ram_q);
    assign rdata_vld    = rd_q;
    assign cnt_load     = load_pulse;
    assign cnt_load_val = vis_bus;

    AST_PF_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> !rdata_vld); // R8
    AST_WRITE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && wr_en) |=> !rdata_vld); // R2
    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_vld |-> (rdata == 8'h00)); // R1

endmodule

// File: tb/test_rtc_bytewide_front.sv
module test_rtc_bytewide_front;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_fail = 1'b0;
    logic        chip_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        out_en = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        cnt_tick = 1'b0;
    logic [55:0] live_time;
    logic [7:0]  rdata;
    logic        rdata_vld;
    logic        cnt_load;
    logic [55:0] cnt_load_val;

    int    vectors = 0;
    int    fails = 0;
    int    cycles = 0;
    bit    chk_on = 1'b0;
    string cur_req = "R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_bytewide_front i_rtc_bytewide_front (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_fail     (pwr_fail),
        .chip_en      (chip_en),
        .wr_en        (wr_en),
        .out_en       (out_en),
        .addr         (addr),
        .wdata        (wdata),
        .cnt_tick     (cnt_tick),
        .live_time    (live_time),
        .rdata        (rdata),
        .rdata_vld    (rdata_vld),
        .cnt_load     (cnt_load),
        .cnt_load_val (cnt_load_val)
    );

    // ---------------- reference model ----------------
    logic [7:0] ram_m [int];
    logic [7:0] vis_m [7];
    logic [7:0] live_m [7];
    logic       m_w, m_r, m_commit, m_vld;
    logic [5:0] m_spare;
    logic [7:0] m_rdata;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    function automatic logic [55:0] pack_vis();
        logic [55:0] p;
        for (int i = 0; i < 7; i++) p[i*8 +: 8] = vis_m[i];
        return p;
    endfunction

    always_comb begin
        for (int i = 0; i < 7; i++) live_time[i*8 +: 8] = live_m[i];
    end

    always @(posedge clk or negedge rst_n) begin
        logic       ce, rd, wr, nw, nr;
        logic [7:0] nv [7];
        logic [7:0] peek;
        int         idx;
        if (!rst_n) begin
            m_w <= 0; m_r <= 0; m_commit <= 0; m_vld <= 0; m_spare <= 0; m_rdata <= 0;
            for (int i = 0; i < 7; i++) vis_m[i] <= 8'h00;
            live_m[0] <= 8'h50; live_m[1] <= 8'h59; live_m[2] <= 8'h23; live_m[3] <= 8'h04;
            live_m[4] <= 8'h29; live_m[5] <= 8'h02; live_m[6] <= 8'h24;
        end else begin
            ce = chip_en && !pwr_fail;
            rd = ce && out_en && !wr_en;
            wr = ce && wr_en;
            peek = 8'h00;
            if (addr == 15'h7FF8) peek = {m_w, m_r, m_spare};
            else if (addr > 15'h7FF8) peek = vis_m[int'(addr) - 'h7FF9];
            else if (ram_m.exists(int'(addr) % 1024)) peek = ram_m[int'(addr) % 1024];
            m_vld   <= rd;
            m_rdata <= rd ? peek : 8'h00;
            if (wr && addr < 15'h7FF8) ram_m[int'(addr) % 1024] = wdata;
            nw = m_w; nr = m_r;
            if (wr && addr == 15'h7FF8) begin
                nw = wdata[7]; nr = wdata[6]; m_spare <= wdata[5:0];
            end
            m_commit <= m_w && !nw;
            m_w <= nw; m_r <= nr;
            for (int i = 0; i < 7; i++) begin
                nv[i] = vis_m[i];
                if (cnt_tick && !m_w && !m_r && !m_commit) nv[i] = live_m[i];
            end
            if (wr && addr > 15'h7FF8) begin
                idx = int'(addr) - 'h7FF9;
                nv[idx] = wdata;
            end
            for (int i = 0; i < 7; i++) vis_m[i] <= nv[i];
            if (m_commit) begin
                for (int i = 0; i < 7; i++) live_m[i] <= vis_m[i];
            end else if (cnt_tick) begin
                live_m[0] <= bcd_inc(live_m[0]);
                if (live_m[0] == 8'h59) begin
                    live_m[0] <= 8'h00;
                    live_m[1] <= (live_m[1] == 8'h59) ? 8'h00 : bcd_inc(live_m[1]);
                end
            end
        end
    end

    // ---------------- comparison, every clock ----------------
    always @(negedge clk) begin
        cycles++;
        if (chk_on) begin
            vectors++;
            if (rdata_vld !== m_vld || rdata !== m_rdata) begin
                fails++;
                $display("FAIL %s: rdata_vld/rdata = %0b/%h expected %0b/%h (addr %h)",
                         cur_req, rdata_vld, rdata, m_vld, m_rdata, addr);
            end
            if (cnt_load !== m_commit || (m_commit && cnt_load_val !== pack_vis())) begin
                fails++;
                $display("FAIL %s: cnt_load/val = %0b/%h expected %0b/%h",
                         cur_req, cnt_load, cnt_load_val, m_commit, pack_vis());
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(input bit ce, input bit we, input bit oe, input logic [14:0] a,
                        input logic [7:0] d, input bit tk, input bit pf);
        @(negedge clk);
        chip_en = ce; wr_en = we; out_en = oe; addr = a; wdata = d; cnt_tick = tk; pwr_fail = pf;
    endtask

    task automatic bwr(input logic [14:0] a, input logic [7:0] d);
        step(1, 1, 0, a, d, 0, 0);
    endtask

    task automatic brd(input logic [14:0] a);
        step(1, 0, 1, a, 8'h00, 0, 0);
    endtask

    task automatic idle(input bit tk);
        step(0, 0, 0, 15'h0, 8'h00, tk, 0);
    endtask

    task automatic read_time();
        for (int s = 9; s <= 15; s++) brd(15'h7FF0 + 15'(s));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1'b1;

        // R9: reset state
        cur_req = "R9";
        idle(0); brd(15'h7FF8); brd(15'h7FF9); brd(15'h7FFF); idle(0);

        // R1: RAM map and aliasing
        cur_req = "R1";
        bwr(15'h0000, 8'hA5); bwr(15'h1234, 8'h3C); bwr(15'h7FF7, 8'h77);
        brd(15'h0000); brd(15'h1234); brd(15'h0234); brd(15'h03F7); idle(0);

        // R2: decode and write priority
        cur_req = "R2";
        step(1, 1, 1, 15'h0010, 8'h11, 0, 0);
        brd(15'h0010);
        step(0, 1, 0, 15'h0010, 8'h99, 0, 0);
        brd(15'h0010);
        step(0, 0, 1, 15'h0010, 8'h00, 0, 0);
        idle(0);

        // R3: tracking
        cur_req = "R3";
        idle(1); read_time(); idle(1); idle(1); read_time();
        for (int k = 0; k < 12; k++) idle(1);
        read_time();

        // R4: hold-read freezes
        cur_req = "R4";
        bwr(15'h7FF8, 8'h40);
        for (int k = 0; k < 4; k++) begin idle(1); brd(15'h7FF9); brd(15'h7FFA); end
        step(1, 0, 1, 15'h7FF9, 8'h00, 1, 0);
        brd(15'h7FF8);

        // R5: release and refresh
        cur_req = "R5";
        bwr(15'h7FF8, 8'h00); brd(15'h7FF9); idle(1); read_time();

        // R6: set-time staging
        cur_req = "R6";
        bwr(15'h7FF8, 8'h80); idle(1);
        bwr(15'h7FF9, 8'h30); bwr(15'h7FFA, 8'h15); bwr(15'h7FFB, 8'h08); bwr(15'h7FFC, 8'h01);
        bwr(15'h7FFD, 8'h31); bwr(15'h7FFE, 8'h12); bwr(15'h7FFF, 8'h99);
        idle(1); read_time(); brd(15'h7FF8);

        // R7: commit into counters, then resume
        cur_req = "R7";
        bwr(15'h7FF8, 8'h00); idle(0); idle(0); idle(1); idle(1); read_time();
        bwr(15'h7FF8, 8'hC0); bwr(15'h7FF9, 8'h45); bwr(15'h7FF8, 8'h40);
        idle(1); idle(1); read_time(); brd(15'h7FF8);
        bwr(15'h7FF8, 8'h00); idle(1); read_time();
        bwr(15'h7FF8, 8'h80); step(1, 1, 0, 15'h7FF8, 8'h00, 1, 0); idle(1); idle(1); read_time();

        // R9: spare control bits
        cur_req = "R9";
        bwr(15'h7FF8, 8'h2A); brd(15'h7FF8); bwr(15'h7FF8, 8'h55); brd(15'h7FF8);
        bwr(15'h7FF8, 8'h00); idle(0);

        // R8: power fail blocks everything
        cur_req = "R8";
        step(1, 1, 0, 15'h0010, 8'hEE, 0, 1);
        step(1, 1, 0, 15'h7FF8, 8'h80, 0, 1);
        step(1, 1, 0, 15'h7FFA, 8'h77, 0, 1);
        step(1, 0, 1, 15'h0010, 8'h00, 0, 1);
        step(1, 0, 1, 15'h7FF8, 8'h00, 0, 1);
        brd(15'h0010); brd(15'h7FF8); brd(15'h7FFA); idle(1); read_time();
        idle(0); idle(0);

        chk_on = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        wait (cycles >= WATCHDOG);
        fails++;
        $display("FAIL watchdog: run did not finish, cycles %0d expected < %0d", cycles, WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule